// File: doc/BRIEF.md
# Idle and Power-Down Mode Controller

This block decides which low-power state a microcontroller core is in (Active, Idle or Power Down) and drives the clock and watchdog enables that follow from that state. The core signals a sleep wish with a one-cycle idle or power-down strobe. The block enters the new state only when the external SDRAM reports that it is in self-refresh. Until then the wish is held pending.

In Idle, an interrupt source can wake the core only if its enable was set at the moment Idle was entered. Two cases follow from a pending source. If it is a peripheral event controller (PEC) transfer with the global enable set and a priority above the CPU level, the CPU clock runs only for that transfer, and the block drops back to Idle when the transfer reports done. Any other enabled source wakes the core for good, even when it will never be serviced. A vector fetch is requested only for a wake that the CPU will actually service. Power Down stops every clock and the watchdog, and only the asynchronous external reset ends it.

Top module: `lp_mode_ctl`

## Requirements
- R1: While `rst_n` is low, and after it is released, the block is Active: `cpu_clk_en`, `per_clk_en` and `wdt_run` are 1, and `wake`, `vec_req` and `pec_stb` are 0. The reset acts without waiting for a clock edge.
- R2: An idle strobe with `sr_ack` high and no enabled pending request puts the block in Idle at the next edge. In Idle `cpu_clk_en` is 0 and `per_clk_en` is 1.
- R3: If `sr_ack` is low when an idle or power-down strobe arrives, the request is held. The state changes at the first edge at which `sr_ack` is high.
- R4: An enabled pending request (`irq_pend[i]` and `irq_en[i]` both high) in the same cycle as the idle strobe cancels Idle entry, and the block stays Active.
- R5: In Idle, a pending source whose enable was set at entry ends Idle at the next edge with a one-cycle `wake` pulse, whatever its priority. A source enabled only after entry has no effect.
- R6: `vec_req` pulses together with `wake` only if `gie` is 1 and the waking source has a nonzero priority above `cpu_prio`. A level-0 source, or a wake with `gie` at 0, gives `wake` without `vec_req`.
- R7: After a wake the block stays Active once the request has gone.
- R8: In Idle, a pending enabled source with `pec_sel` set, `gie` 1 and a priority above `cpu_prio` starts a PEC service. This gives a one-cycle `pec_stb`, `cpu_clk_en` at 1 and no `wake`. The block returns to Idle at the edge after `pec_done` is seen.
- R9: A source with `pec_sel` set but with a priority not above `cpu_prio` (or with `gie` at 0) is handled as a CPU request and wakes the core.
- R10: In Power Down `cpu_clk_en`, `per_clk_en` and `wdt_run` are 0. Interrupt requests have no effect there, and only `rst_n` leaves the state.
- R11: `wdt_run` is 1 in Active, Idle and during a PEC service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous external reset, active low |
| idle_req | input | 1 | Idle instruction strobe |
| pdown_req | input | 1 | Power-down instruction strobe |
| irq_pend | input | NSRC | Per-source interrupt request |
| irq_en | input | NSRC | Per-source enable flag |
| irq_prio | input | NSRC*PW | Per-source priority, source i at bits [i*PW +: PW] |
| pec_sel | input | NSRC | Source i is a PEC transfer |
| gie | input | 1 | Global interrupt enable |
| cpu_prio | input | PW | Current CPU priority level |
| pec_done | input | 1 | PEC transfer finished |
| sr_ack | input | 1 | SDRAM is in self-refresh |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| wdt_run | output | 1 | Watchdog run enable |
| wake | output | 1 | One-cycle pulse when Idle ends |
| vec_req | output | 1 | One-cycle vector-fetch request on wake |
| pec_stb | output | 1 | One-cycle PEC service start |

## Verification
Every result comes from one register stage. Inputs driven before edge k therefore show as state-driven enables and one-cycle pulses just after edge k, and the pulses are gone after edge k+1. The only exception is the reset, which acts at once. The driver sets inputs on the falling edge and queues exactly one expected output word per cycle. The monitor compares that word 1 ns after the following rising edge, so every check lands one register after its stimulus. Reset is checked directly, 1 ns after `rst_n` falls in the middle of a cycle.

// File: rtl/lp_mode_ctl.sv
module lp_mode_ctl #(
  parameter int NSRC = 4,
  parameter int PW   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle_req,
  input  logic              pdown_req,
  input  logic [NSRC-1:0]   irq_pend,
  input  logic [NSRC-1:0]   irq_en,
  input  logic [NSRC*PW-1:0] irq_prio,
  input  logic [NSRC-1:0]   pec_sel,
  input  logic              gie,
  input  logic [PW-1:0]     cpu_prio,
  input  logic              pec_done,
  input  logic              sr_ack,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              wdt_run,
  output logic              wake,
  output logic              vec_req,
  output logic              pec_stb
);
  typedef enum logic [1:0] {S_ACT, S_IDLE, S_PEC, S_PD} st_t;
  st_t st;
  logic idle_pend, pd_pend;
  logic [NSRC-1:0] en_snap, hit, pec_ok, vec_ok;

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      pec_ok[i] = gie & pec_sel[i] & (irq_prio[i*PW +: PW] > cpu_prio);
      vec_ok[i] = gie & (irq_prio[i*PW +: PW] != '0) & (irq_prio[i*PW +: PW] > cpu_prio);
    end
  end

  assign hit = irq_pend & en_snap;
  wire act_req = |(irq_pend & irq_en);
  wire cpu_hit = |(hit & ~pec_ok);
  wire pec_hit = |(hit & pec_ok);

  assign cpu_clk_en = (st == S_ACT) || (st == S_PEC);
  assign per_clk_en = (st != S_PD);
  assign wdt_run    = (st != S_PD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_ACT; idle_pend <= 1'b0; pd_pend <= 1'b0; en_snap <= '0;
      wake <= 1'b0; vec_req <= 1'b0; pec_stb <= 1'b0;
    end else begin
      wake <= 1'b0; vec_req <= 1'b0; pec_stb <= 1'b0;
      case (st)
        S_ACT: begin
          if (pdown_req || pd_pend) begin
            if (sr_ack) begin
              st <= S_PD; pd_pend <= 1'b0; idle_pend <= 1'b0;
            end else pd_pend <= 1'b1;
          end else if (idle_req || idle_pend) begin
            if (act_req) idle_pend <= 1'b0;
            else if (sr_ack) begin
              st <= S_IDLE; en_snap <= irq_en; idle_pend <= 1'b0;
            end else idle_pend <= 1'b1;
          end
        end
        S_IDLE: begin
          if (cpu_hit) begin
            st <= S_ACT; wake <= 1'b1; vec_req <= |(hit & vec_ok);
          end else if (pec_hit) begin
            st <= S_PEC; pec_stb <= 1'b1;
          end
        end
        S_PEC: if (pec_done) st <= S_IDLE;
        default: st <= S_PD;
      endcase
    end
  end

  AST_PD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !per_clk_en |=> (!per_clk_en && !cpu_clk_en && !wdt_run)); // R10
  AST_WAKE_RUNS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (cpu_clk_en && !pec_stb)); // R5
  AST_VEC_NEEDS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> (wake && $past(gie))); // R6
  AST_PEC_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    pec_stb |-> (cpu_clk_en && per_clk_en && $past(gie))); // R8
  AST_GATE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cpu_clk_en) && per_clk_en) |-> ($past(sr_ack) || $past(pec_done))); // R3
  AST_WDT_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    per_clk_en |-> wdt_run); // R11
endmodule

// File: tb/sim_lp_mode_ctl.sv
module sim_lp_mode_ctl;
  localparam int NSRC = 4, PW = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic idle_req = 0, pdown_req = 0, gie = 1, pec_done = 0, sr_ack = 1;
  logic [NSRC-1:0] irq_pend = '0, irq_en = '0, pec_sel = '0;
  logic [NSRC*PW-1:0] irq_prio = '0;
  logic [PW-1:0] cpu_prio = 4'd2;
  logic cpu_clk_en, per_clk_en, wdt_run, wake, vec_req, pec_stb;
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [5:0] exp_q[$];
  string tag_q[$];
  logic done = 1'b0;

  localparam logic [5:0] A = 6'b111000, I = 6'b011000, PD = 6'b000000;

  always #2 clk = ~clk;

  lp_mode_ctl #(.NSRC(NSRC), .PW(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .pdown_req(pdown_req),
    .irq_pend(irq_pend), .irq_en(irq_en), .irq_prio(irq_prio), .pec_sel(pec_sel),
    .gie(gie), .cpu_prio(cpu_prio), .pec_done(pec_done), .sr_ack(sr_ack),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .wdt_run(wdt_run),
    .wake(wake), .vec_req(vec_req), .pec_stb(pec_stb));

  wire [5:0] outs = {cpu_clk_en, per_clk_en, wdt_run, wake, vec_req, pec_stb};

  task automatic check(input string tag, input logic [5:0] e);
    n_chk++;
    if (outs !== e) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, outs, e);
    end
  endtask

  task automatic step(input string tag, input logic [5:0] e);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  always begin
    @(posedge clk);
    cyc++;
    #1;
    if (exp_q.size() > 0) check(tag_q.pop_front(), exp_q.pop_front());
  end

  initial begin
    #3;
    check("R1 in reset", A);
    @(negedge clk); rst_n = 1'b1; irq_en = 4'b0011;
    step("R1 after release", A);
    irq_pend[0] = 1; irq_en[0] = 1; idle_req = 1;
    step("R4 cancel", A);
    irq_pend = '0; idle_req = 0;
    step("R4 stays active", A);
    idle_req = 1;
    step("R2 enter idle", I);
    idle_req = 0;
    step("R2 hold idle", I);
    irq_en[2] = 1; irq_pend[2] = 1;
    step("R5 late enable ignored", I);
    irq_en[2] = 0; irq_pend[2] = 0; irq_prio[7:4] = 4'd0; irq_pend[1] = 1;
    step("R5 R6 level0 wake", 6'b111100);
    irq_pend = '0;
    step("R7 stays active", A);
    sr_ack = 0; idle_req = 1;
    step("R3 held", A);
    idle_req = 0;
    step("R3 still held", A);
    sr_ack = 1;
    step("R3 enter on ack", I);
    irq_prio[3:0] = 4'd5; irq_pend[0] = 1;
    step("R6 vector wake", 6'b111110);
    irq_pend = '0; idle_req = 1;
    step("R2 reenter", I);
    idle_req = 0; gie = 0; irq_pend[0] = 1;
    step("R6 gie0 no vector", 6'b111100);
    irq_pend = '0; gie = 1; idle_req = 1;
    step("R2 reenter2", I);
    idle_req = 0; pec_sel[0] = 1; irq_pend[0] = 1;
    step("R8 pec start", 6'b111001);
    irq_pend = '0;
    step("R8 R11 pec running", A);
    pec_done = 1;
    step("R8 back to idle", I);
    pec_done = 0;
    step("R8 idle holds", I);
    irq_prio[3:0] = 4'd1; irq_pend[0] = 1;
    step("R9 low pec wakes", 6'b111100);
    irq_pend = '0; sr_ack = 0; pdown_req = 1;
    step("R3 pd held", A);
    pdown_req = 0;
    step("R3 pd still held", A);
    sr_ack = 1;
    step("R10 enter pd", PD);
    irq_pend = '1; irq_en = '1;
    step("R10 R11 irq ignored", PD);
    step("R10 stays pd", PD);
    irq_pend = '0;
    #1 rst_n = 1'b0;
    #1 check("R10 R1 reset exits pd", A);
    @(negedge clk); rst_n = 1'b1;
    step("R1 active after exit", A);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    wait (done || cyc > 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule